// File: doc/BRIEF.md
# Multi-Pattern Lamp Chaser Sequencer

This block drives a row of lamp outputs through a repeating programme of moving light patterns. A slow programme tick advances a ten-step programme counter. Each step is looked up in a parameterised table that names one of three behaviours: fill, clear or blink.

In a fill step, ones enter a serial-in, parallel-out lamp chain at a slow rate, so the lit run grows by one lamp per shift. In a clear step, zeros enter at a fast rate and the row empties quickly. In a blink step, ones enter at the fast rate and a periodic blink tick wipes the whole chain, so the row flashes full and dark.

Every rate comes from one system clock through free-running dividers. Each divider produces a single-cycle enable pulse, and simulation shrinks the dividers by parameter. A one-bit source register sits between the decode and the chain and supplies the bit that is shifted in.

Top module: `chaser_seq`

## Requirements
- R1: While `rst` is high at a clock edge, all dividers, the programme counter, the source bit and every lamp are cleared, so `lamps_o` reads all zeros the cycle after.
- R2: Each divider of period P pulses for one cycle at every P-th cycle after reset: the first pulse comes P-1 cycles after reset is released. The programme counter advances by one on each programme pulse and wraps from 9 to 0.
- R3: The behaviour code of step s is bits [2s+1:2s] of the table, with 0 = fill, 1 = clear and 2 = blink. The default table gives fill to steps 0, 1, 3, 4 and 8, clear to steps 2, 5 and 9, and blink to steps 6 and 7.
- R4: In a fill step, the chain shifts once on each slow-rate pulse.
- R5: In a clear step, the chain shifts once on each fast-rate pulse. At most one shift source is active in any cycle.
- R6: In a blink step, a blink pulse clears all lamps at the next edge and takes priority over a shift in the same cycle.
- R7: In a blink step without a blink pulse, the chain shifts once on each fast-rate pulse.
- R8: The source bit is registered. It holds 0 in the cycle after a clear step and 1 in the cycle after any other step. A shift uses the value it holds at that edge.
- R9: In a cycle with no shift and no clear, `lamps_o` holds its value.
- R10: A shift moves every lamp from index i to i+1, drops lamp 31 and loads the source bit into lamp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lamps_o | output | 32 | Lamp drive vector; bit 0 receives each new bit |

## Verification
A wrong programme counter or table entry shows up as a shift at the wrong rate or with the wrong bit. It is visible at `lamps_o` on the first pulse after the faulty step begins: at most one slow period late, or one fast period late in clear and blink steps. A stuck or late source bit shows up in lamp 0 on the first shift after a step boundary. A broken blink path leaves lamps lit one cycle after a blink pulse. The bench compares `lamps_o` against a behavioural model on every clock, so each of these faults shows up within a single cycle of its first visible effect.

// File: rtl/chaser_pkg.sv
package chaser_pkg;

  typedef enum logic [1:0] {
    PAT_FILL  = 2'd0,
    PAT_CLEAR = 2'd1,
    PAT_BLINK = 2'd2
  } pat_e;

  function automatic pat_e code_to_pat(input logic [1:0] code);
    case (code)
      2'd0:    return PAT_FILL;
      2'd2:    return PAT_BLINK;
      default: return PAT_CLEAR;
    endcase
  endfunction

  function automatic logic src_bit_for(input pat_e p);
    return (p != PAT_CLEAR);
  endfunction

endpackage

// File: rtl/chaser_tick_div.sv
module chaser_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/chaser_mode_ctr.sv
module chaser_mode_ctr
  import chaser_pkg::*;
#(
  parameter int NUM_STATES = 10,
  parameter logic [2*NUM_STATES-1:0] MODE_MAP = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output pat_e pat_o
);
  localparam int SW = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1;
  localparam logic [SW-1:0] TOP = SW'(NUM_STATES - 1);

  logic [SW-1:0] state_q;

  function automatic logic [SW-1:0] next_state(input logic [SW-1:0] s);
    return (s == TOP) ? '0 : s + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)         state_q <= '0;
    else if (step_i) state_q <= next_state(state_q);
  end

  assign pat_o = code_to_pat(MODE_MAP[2*state_q +: 2]);

  // R2
  state_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && state_q == TOP) |=> (state_q == '0));

  // R2
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(state_q));

  // R2
  state_range_chk: assert property (@(posedge clk) disable iff (rst)
    state_q <= TOP);

endmodule

// File: rtl/chaser_serial_src.sv
module chaser_serial_src
  import chaser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  pat_e pat_i,
  output logic sin_o
);
  always_ff @(posedge clk) begin
    if (rst) sin_o <= 1'b0;
    else     sin_o <= src_bit_for(pat_i);
  end

  // R8
  src_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pat_i == PAT_CLEAR) |=> !sin_o);

  // R8
  src_one_chk: assert property (@(posedge clk) disable iff (rst)
    (pat_i != PAT_CLEAR) |=> sin_o);

endmodule

// File: rtl/chaser_shift_chain.sv
module chaser_shift_chain #(
  parameter int WIDTH   = 32,
  parameter int STAGE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_i,
  input  logic             clr_i,
  input  logic             sin_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int NSTAGE = WIDTH / STAGE_W;

  logic [NSTAGE:0] carry;
  assign carry[0] = sin_i;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic [STAGE_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst || clr_i) r_q <= '0;
      else if (shift_i) r_q <= {r_q[STAGE_W-2:0], carry[g]};
    end
    assign carry[g+1] = r_q[STAGE_W-1];
    assign q_o[g*STAGE_W +: STAGE_W] = r_q;
  end

  // R6
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (q_o == '0));

  // R10
  entry_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !clr_i) |=> (q_o[0] == $past(sin_i)));

  // R10
  exit_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !clr_i) |=> (q_o[WIDTH-1] == $past(q_o[WIDTH-2])));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/chaser_seq.sv
module chaser_seq
  import chaser_pkg::*;
#(
  parameter int LAMPS      = 32,
  parameter int STAGE_W    = 8,
  parameter int NUM_STATES = 10,
  parameter logic [2*NUM_STATES-1:0] MODE_MAP = 20'b01_00_10_10_01_00_00_01_00_00,
  parameter int STEP_DIV   = 625_000_000,
  parameter int BLINK_DIV  = 100_000_000,
  parameter int SLOW_DIV   = 25_000_000,
  parameter int FAST_DIV   = 50_000
) (
  input  logic             clk,
  input  logic             rst,
  output logic [LAMPS-1:0] lamps_o
);
  logic step_tick, blink_tick, slow_tick, fast_tick;
  pat_e pat;
  logic sin;

  chaser_tick_div #(.DIV(STEP_DIV))  u_step  (.clk(clk), .rst(rst), .tick_o(step_tick));
  chaser_tick_div #(.DIV(BLINK_DIV)) u_blink (.clk(clk), .rst(rst), .tick_o(blink_tick));
  chaser_tick_div #(.DIV(SLOW_DIV))  u_slow  (.clk(clk), .rst(rst), .tick_o(slow_tick));
  chaser_tick_div #(.DIV(FAST_DIV))  u_fast  (.clk(clk), .rst(rst), .tick_o(fast_tick));

  chaser_mode_ctr #(.NUM_STATES(NUM_STATES), .MODE_MAP(MODE_MAP)) u_mode (
    .clk(clk), .rst(rst), .step_i(step_tick), .pat_o(pat));

  chaser_serial_src u_src (.clk(clk), .rst(rst), .pat_i(pat), .sin_o(sin));

  // named shift and clear events
  logic fill_shift, clear_shift, refill_shift, blink_clr, any_shift;
  assign fill_shift   = (pat == PAT_FILL)  && slow_tick;
  assign clear_shift  = (pat == PAT_CLEAR) && fast_tick;
  assign refill_shift = (pat == PAT_BLINK) && fast_tick;
  assign blink_clr    = (pat == PAT_BLINK) && blink_tick;
  assign any_shift    = fill_shift | clear_shift | refill_shift;

  chaser_shift_chain #(.WIDTH(LAMPS), .STAGE_W(STAGE_W)) u_chain (
    .clk(clk), .rst(rst), .shift_i(any_shift), .clr_i(blink_clr),
    .sin_i(sin), .q_o(lamps_o));

  // R5
  one_source_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fill_shift, clear_shift, refill_shift}));

  // R1
  reset_dark_chk: assert property (@(posedge clk)
    rst |=> (lamps_o == '0));

endmodule

// File: tb/chaser_seq_bench.sv
module chaser_seq_bench;
  localparam int W     = 32;
  localparam int STEP  = 200;
  localparam int BLINK = 80;
  localparam int SLOW  = 5;
  localparam int FAST  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] lamps;

  int n_vec = 0;
  int n_bad = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  chaser_seq #(.STEP_DIV(STEP), .BLINK_DIV(BLINK), .SLOW_DIV(SLOW), .FAST_DIV(FAST))
    u_chaser_seq (.clk(clk), .rst(rst), .lamps_o(lamps));

  // reference model state
  bit  lamp_q[$];
  int  c_step, c_blink, c_slow, c_fast, m_step;
  bit  m_src;
  string last_ev = "R1";

  // R3: default programme table, 0 fill, 1 clear, 2 blink
  function automatic int ref_kind(input int s);
    case (s)
      2, 5, 9: return 1;
      6, 7:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [W-1:0] ref_vec();
    logic [W-1:0] v = '0;
    for (int i = 0; i < W; i++) v[i] = lamp_q[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      lamp_q = {};
      for (int i = 0; i < W; i++) lamp_q.push_back(1'b0);
      c_step = 0; c_blink = 0; c_slow = 0; c_fast = 0;
      m_step = 0; m_src = 1'b0;
      last_ev = "R1";
    end else begin
      int  kind;
      bit  t_step, t_blink, t_slow, t_fast, sh;
      kind    = ref_kind(m_step);
      // R2: each rate pulses every period-th cycle
      t_step  = (c_step  == STEP  - 1);
      t_blink = (c_blink == BLINK - 1);
      t_slow  = (c_slow  == SLOW  - 1);
      t_fast  = (c_fast  == FAST  - 1);
      sh = (kind == 0 && t_slow) || (kind != 0 && t_fast);
      if (kind == 2 && t_blink) begin
        for (int i = 0; i < W; i++) lamp_q[i] = 1'b0;
        last_ev = "R6";
      end else if (sh) begin
        // R10: new bit enters lamp 0, lamp 31 falls off
        lamp_q.push_front(m_src);
        void'(lamp_q.pop_back());
        last_ev = (kind == 0) ? "R4" : (kind == 1) ? "R5" : "R7";
      end else begin
        last_ev = "R9";
      end
      // R8: source bit reflects the step seen in this cycle
      m_src = (kind != 1);
      if (t_step) m_step = (m_step + 1) % 10;
      c_step  = t_step  ? 0 : c_step  + 1;
      c_blink = t_blink ? 0 : c_blink + 1;
      c_slow  = t_slow  ? 0 : c_slow  + 1;
      c_fast  = t_fast  ? 0 : c_fast  + 1;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      logic [W-1:0] exp_v;
      exp_v = ref_vec();
      n_vec++;
      if (lamps !== exp_v) begin
        n_bad++;
        $display("FAIL %s (R2/R3/R8 sequence): lamps=%h expected=%h", last_ev, lamps, exp_v);
      end
    end
  end

  int wd = 0;
  bit timed_out = 1'b0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150_000 && !timed_out) begin
      timed_out = 1'b1;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", wd, 150_000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: dark while reset is held
    n_vec++;
    if (lamps !== '0) begin
      n_bad++;
      $display("FAIL R1: lamps=%h expected=%h", lamps, {W{1'b0}});
    end
    rst = 1'b0;
    running = 1'b1;
    repeat (2 * 10 * STEP + 40) @(negedge clk);
    // R1: reset mid-run clears everything again
    rst = 1'b1;
    running = 1'b0;
    @(negedge clk);
    n_vec++;
    if (lamps !== '0) begin
      n_bad++;
      $display("FAIL R1: lamps=%h expected=%h", lamps, {W{1'b0}});
    end
    rst = 1'b0;
    running = 1'b1;
    repeat (3 * STEP) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule